// File: doc/BRIEF.md
# SDRAM Power-State and Reset Sequencer

This block governs how the SDRAM side of a four-bank memory controller comes out of reset and low-power operation. After reset the interface sits in self-refresh with its clock stopped. Software then walks it, one register write per step, through self-refresh with the clock running, power-down, power-down exit and finally idle. The block drives the SDRAM clock-enable, the clock-run gating of three memory clock outputs, and the per-bank row and column strobes. It also remembers whether the last reset was a hardware reset or a sleep reset.

A sleep reset keeps every row and column strobe asserted, so that asynchronous DRAM stays in self-refresh until software writes a release strobe. A hardware reset starts a power-on settling delay that must run out before the first step is accepted. The bank enables reset to all-disabled. While a bank is disabled, a non-burst access to it does no data transfer. Instead it fires a single CAS-before-RAS refresh across all four banks at once and counts it, so boot code can issue the customary eight warm-up refreshes. The block also holds the reset value of the chip-select-0 static timing word.

Top module: `sdram_pwr_seq`

## Requirements
- R1: The power state `pwr_state` is 0 after any reset. It changes only on an accepted `wr_step` whose `wr_target` equals the current state plus one. The codes are 0 = self-refresh with clock stopped, 1 = self-refresh, 2 = power-down, 3 = power-down exit and 4 = idle. The new state is visible one clock after the write.
- R2: A `wr_step` write is ignored and sets the sticky `seq_err` flag in any of these cases: its target is not the current state plus one, the state is already idle, or the power-on wait is still running. `seq_err` clears only on reset.
- R3: `sd_cke` is low in states 0, 1 and 2, and high in states 3 and 4. It changes on the same clock as the state.
- R4: After a hardware reset, `por_busy` stays high for exactly PWRON_CYCLES clock edges after reset is released. No step out of state 0 is accepted while it is high. After a sleep reset, `por_busy` is low at once.
- R5: `mclk0` toggles on every clock, which is half the input rate, while `boot_strap` is high or the state is not 0. `mclk1` and `mclk2` stay at 0 in state 0 and toggle on every clock once state 0 has been left.
- R6: After a sleep reset, all four `ras_n` and all four `cas_n` bits are 0 until a `wr_release` strobe. After a hardware reset they are all 1 except during a refresh pulse.
- R7: `bank_en` is 0000 after any reset and takes `bank_en_in` one clock after a `wr_bank` strobe. An access in that same cycle still sees the old enables.
- R8: An access (`acc_req`=1) that is non-burst (`acc_burst`=0) to a disabled bank (`bank_en[acc_bank]`=0) raises `rfsh_pulse` for exactly one clock, starting one clock later. During that clock all `ras_n` and `cas_n` bits are 0, and `rfsh_cnt` goes up by one, saturating at its maximum. A burst access to a disabled bank does nothing.
- R9: An access to an enabled bank raises `acc_fwd` for one clock, one clock later, and never raises a refresh.
- R10: `cs0_timing` resets to {3'b111, 5'b11111, 5'b11111, ~rom_sel, 2'b00}, with bit 15 as the MSB, and holds that value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_sleep | input | 1 | Sampled during reset: 1 = sleep reset, 0 = hardware reset |
| boot_strap | input | 1 | Strap that lets mclk0 run while the clock is otherwise stopped |
| rom_sel | input | 1 | ROM-select strap; its inverse is the reset bus-width bit |
| wr_step | input | 1 | Power-state step write strobe |
| wr_target | input | 3 | Requested power-state code |
| wr_release | input | 1 | Write strobe ending sleep-reset strobe holding |
| wr_bank | input | 1 | Bank enable write strobe |
| bank_en_in | input | 4 | Bank enable write data |
| acc_req | input | 1 | Access request, one cycle |
| acc_burst | input | 1 | Access is a burst |
| acc_bank | input | 2 | Bank addressed by the access |
| pwr_state | output | 3 | Current power-state code |
| sd_cke | output | 1 | SDRAM clock enable |
| por_busy | output | 1 | Power-on wait still running |
| seq_err | output | 1 | Sticky out-of-order step flag |
| mclk0 | output | 1 | Main divided memory clock |
| mclk1 | output | 1 | Auxiliary memory clock 1 |
| mclk2 | output | 1 | Auxiliary memory clock 2 |
| bank_en | output | 4 | Current bank enables |
| ras_n | output | 4 | Row strobe / SDRAM chip select, active low |
| cas_n | output | 4 | Column strobe / mask, active low |
| rfsh_pulse | output | 1 | One-clock all-bank refresh pulse |
| acc_fwd | output | 1 | Access passed on to an enabled bank |
| rfsh_cnt | output | 8 | Saturating count of refreshes issued |
| cs0_timing | output | 16 | Chip-select-0 static timing word |

## Verification
Every registered result is due exactly one rising edge after the stimulus that causes it. This covers the state, the clock enable, the error flag, the bank enables, the refresh and forward pulses, the count and the end of strobe holding. The bench drives inputs just after a falling edge and compares at the next falling edge, so exactly one rising edge lies between stimulus and check. The power-on wait is counted edge by edge from reset release and must end after exactly PWRON_CYCLES edges. The divided clocks are compared between consecutive falling edges, where each running clock must have flipped.

// File: rtl/sps_pkg.sv
// Package: shared power-state codes and reset-value helpers for the
// SDRAM power-state sequencer. Assumes states advance strictly by one.
package sps_pkg;
    typedef enum logic [2:0] {
        PS_SR_STOP = 3'd0,
        PS_SR      = 3'd1,
        PS_PD      = 3'd2,
        PS_PDX     = 3'd3,
        PS_IDLE    = 3'd4
    } pstate_e;

    localparam int TIM_W = 16;

    // Slowest static timing: recovery and both delays at maximum, type zero,
    // bus-width bit taken from the inverted ROM-select strap.
    function automatic logic [TIM_W-1:0] cs0_reset_timing(input logic rom_sel);
        return {3'b111, 5'b11111, 5'b11111, ~rom_sel, 2'b00};
    endfunction
endpackage

// File: rtl/sps_pstate_fsm.sv
// Module: power-state stepper. Holds the power state, accepts only
// single-step software writes, runs the power-on wait after a hardware
// reset and keeps a sticky error for refused writes.
// Assumes rst_sleep is stable while rst_n is low.
module sps_pstate_fsm
    import sps_pkg::*;
#(
    parameter int PWRON_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_sleep,
    input  logic       wr_step,
    input  logic [2:0] wr_target,
    output logic [2:0] state_o,
    output logic       cke_o,
    output logic       run_o,
    output logic       por_busy_o,
    output logic       seq_err_o
);
    localparam int CW = $clog2(PWRON_CYCLES + 1);

    pstate_e       state_q;
    logic [CW-1:0] por_cnt_q;
    logic          cke_q;
    logic          run_q;
    logic          err_q;
    logic [2:0]    next_code;
    logic          step_ok;

    // Decide whether the current write is the one legal next step.
    always_comb begin
        next_code = 3'(state_q) + 3'd1;
        step_ok   = wr_step && (wr_target == next_code) && (state_q != PS_IDLE)
                    && !((state_q == PS_SR_STOP) && (por_cnt_q != '0));
    end

    // Power-on wait counter: loaded on hardware reset, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            por_cnt_q <= rst_sleep ? '0 : CW'(PWRON_CYCLES);
        else if (por_cnt_q != '0)
            por_cnt_q <= por_cnt_q - 1'b1;
    end

    // Power state register, advanced only by an accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_SR_STOP;
        else if (step_ok)
            state_q <= pstate_e'(wr_target);
    end

    // Clock enable and clock-run flags, updated together with the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b0;
            run_q <= 1'b0;
        end else if (step_ok) begin
            cke_q <= (wr_target >= 3'(PS_PDX));
            run_q <= 1'b1;
        end
    end

    // Sticky error flag for refused step writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (wr_step && !step_ok)
            err_q <= 1'b1;
    end

    assign state_o    = 3'(state_q);
    assign cke_o      = cke_q;
    assign run_o      = run_q;
    assign por_busy_o = (por_cnt_q != '0);
    assign seq_err_o  = err_q;

    p_step_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> (3'(state_q) == 3'($past(state_q)) + 3'd1));
    p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_cke_selfref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {PS_SR_STOP, PS_SR, PS_PD}) |-> !cke_q);
    p_por_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (por_cnt_q != '0) |-> (state_q == PS_SR_STOP && !run_q));
endmodule

// File: rtl/sps_clkgen.sv
// Module: divided memory clocks. The main clock toggles each cycle while
// the boot strap is high or the clock-run flag is set; the auxiliary
// clocks toggle only once clock-run is set. Assumes run never drops
// without a reset.
module sps_clkgen #(
    parameter int NUM_AUX = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap,
    input  logic               run,
    output logic               mclk_main,
    output logic [NUM_AUX-1:0] mclk_aux
);
    logic main_q;

    // Main divider: half-rate toggle when strapped on or running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            main_q <= 1'b0;
        else if (strap || run)
            main_q <= ~main_q;
    end

    for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux
        logic aux_q;
        // Auxiliary divider i: half-rate toggle only while running.
        always_ff @(posedge clk) begin
            if (!rst_n)
                aux_q <= 1'b0;
            else if (run)
                aux_q <= ~aux_q;
        end
        assign mclk_aux[i] = aux_q;
    end

    assign mclk_main = main_q;

    p_aux_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (mclk_aux == '0));
    p_main_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap || run) |=> (main_q != $past(main_q)));
endmodule

// File: rtl/sps_refresh.sv
// Module: bank enables and refresh trigger. A non-burst access to a
// disabled bank yields a one-cycle all-bank refresh pulse and bumps a
// saturating counter; an access to an enabled bank is forwarded.
// Assumes acc_req is a one-cycle request.
module sps_refresh #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_bank,
    input  logic [NUM_BANKS-1:0]         bank_en_in,
    input  logic                         acc_req,
    input  logic                         acc_burst,
    input  logic [$clog2(NUM_BANKS)-1:0] acc_bank,
    output logic [NUM_BANKS-1:0]         bank_en_o,
    output logic                         rfsh_o,
    output logic                         fwd_o,
    output logic [CNT_W-1:0]             cnt_o
);
    logic [NUM_BANKS-1:0] en_q;
    logic                 rfsh_q;
    logic                 fwd_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 hit_en;
    logic                 trig;

    // Classify the access against the current bank enables.
    always_comb begin
        hit_en = en_q[acc_bank];
        trig   = acc_req && !acc_burst && !hit_en;
    end

    // Bank enable register, cleared by any reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_bank)
            en_q <= bank_en_in;
    end

    // Refresh and forward pulses plus the saturating refresh counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfsh_q <= 1'b0;
            fwd_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            rfsh_q <= trig;
            fwd_q  <= acc_req && hit_en;
            if (trig && (cnt_q != '1))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bank_en_o = en_q;
    assign rfsh_o    = rfsh_q;
    assign fwd_o     = fwd_q;
    assign cnt_o     = cnt_q;

    p_rfsh_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_q && ($past(cnt_q) != '1)) |-> (cnt_q == $past(cnt_q) + 1'b1));
    p_rfsh_fwd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rfsh_q && fwd_q));
endmodule

// File: rtl/sps_strobes.sv
// Module: row and column strobe drivers. A sleep reset sets a hold that
// drives every strobe low until a release write; a refresh pulse also
// drives every strobe low. Assumes rst_sleep is valid during reset.
module sps_strobes #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_sleep,
    input  logic                 wr_release,
    input  logic                 rfsh,
    output logic [NUM_BANKS-1:0] ras_n,
    output logic [NUM_BANKS-1:0] cas_n
);
    logic hold_q;

    // Sleep-reset hold flag, cleared only by an explicit release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= rst_sleep;
        else if (wr_release)
            hold_q <= 1'b0;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Per-bank strobe drive: low while held or refreshing.
        always_comb begin
            ras_n[b] = !(hold_q || rfsh);
            cas_n[b] = !(hold_q || rfsh);
        end
    end

    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (ras_n == '0 && cas_n == '0));
    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_release) |-> !hold_q);
endmodule

// File: rtl/sdram_pwr_seq.sv
// Module: top of the SDRAM power-state and reset sequencer. Ties the
// stepper, clock dividers, refresh trigger and strobe drivers together
// and holds the chip-select-0 static timing reset value.
// Assumes a single memory clock domain and synchronous reset.
module sdram_pwr_seq
    import sps_pkg::*;
#(
    parameter int PWRON_CYCLES = 64,
    parameter int NUM_BANKS    = 4,
    parameter int CNT_W        = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rst_sleep,
    input  logic                         boot_strap,
    input  logic                         rom_sel,
    input  logic                         wr_step,
    input  logic [2:0]                   wr_target,
    input  logic                         wr_release,
    input  logic                         wr_bank,
    input  logic [NUM_BANKS-1:0]         bank_en_in,
    input  logic                         acc_req,
    input  logic                         acc_burst,
    input  logic [$clog2(NUM_BANKS)-1:0] acc_bank,
    output logic [2:0]                   pwr_state,
    output logic                         sd_cke,
    output logic                         por_busy,
    output logic                         seq_err,
    output logic                         mclk0,
    output logic                         mclk1,
    output logic                         mclk2,
    output logic [NUM_BANKS-1:0]         bank_en,
    output logic [NUM_BANKS-1:0]         ras_n,
    output logic [NUM_BANKS-1:0]         cas_n,
    output logic                         rfsh_pulse,
    output logic                         acc_fwd,
    output logic [CNT_W-1:0]             rfsh_cnt,
    output logic [TIM_W-1:0]             cs0_timing
);
    localparam int NUM_AUX = 2;

    logic               run;
    logic [NUM_AUX-1:0] aux;
    logic [TIM_W-1:0]   tim_q;

    sps_pstate_fsm #(.PWRON_CYCLES(PWRON_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sleep  (rst_sleep),
        .wr_step    (wr_step),
        .wr_target  (wr_target),
        .state_o    (pwr_state),
        .cke_o      (sd_cke),
        .run_o      (run),
        .por_busy_o (por_busy),
        .seq_err_o  (seq_err)
    );

    sps_clkgen #(.NUM_AUX(NUM_AUX)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (boot_strap),
        .run       (run),
        .mclk_main (mclk0),
        .mclk_aux  (aux)
    );

    sps_refresh #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_rfsh (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_bank    (wr_bank),
        .bank_en_in (bank_en_in),
        .acc_req    (acc_req),
        .acc_burst  (acc_burst),
        .acc_bank   (acc_bank),
        .bank_en_o  (bank_en),
        .rfsh_o     (rfsh_pulse),
        .fwd_o      (acc_fwd),
        .cnt_o      (rfsh_cnt)
    );

    sps_strobes #(.NUM_BANKS(NUM_BANKS)) u_strb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sleep  (rst_sleep),
        .wr_release (wr_release),
        .rfsh       (rfsh_pulse),
        .ras_n      (ras_n),
        .cas_n      (cas_n)
    );

    // Chip-select-0 timing word: loaded with the slowest setting on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tim_q <= cs0_reset_timing(rom_sel);
    end

    assign mclk1      = aux[0];
    assign mclk2      = aux[1];
    assign cs0_timing = tim_q;

    p_tim_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(tim_q));
    p_refresh_strobes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_pulse |-> (ras_n == '0 && cas_n == '0));
endmodule

// File: tb/sdram_pwr_seq_tb.sv
module sdram_pwr_seq_tb;
    localparam int PWR = 64;

    logic clk = 1'b0;
    logic rst_n, rst_sleep, boot_strap, rom_sel;
    logic wr_step, wr_release, wr_bank, acc_req, acc_burst;
    logic [2:0] wr_target;
    logic [3:0] bank_en_in;
    logic [1:0] acc_bank;
    logic [2:0] pwr_state;
    logic sd_cke, por_busy, seq_err, mclk0, mclk1, mclk2, rfsh_pulse, acc_fwd;
    logic [3:0] bank_en, ras_n, cas_n;
    logic [7:0] rfsh_cnt;
    logic [15:0] cs0_timing;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_pwr_seq #(.PWRON_CYCLES(PWR)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_tim(input logic rs);
        return {3'b111, 10'h3FF, ~rs, 2'b00};
    endfunction

    function automatic bit exp_cke(input int st);
        return st >= 3;
    endfunction

    task automatic idle_inputs();
        wr_step = 0; wr_target = 0; wr_release = 0; wr_bank = 0;
        bank_en_in = 0; acc_req = 0; acc_burst = 0; acc_bank = 0;
    endtask

    task automatic do_reset(input logic sleep);
        idle_inputs();
        rst_n = 0; rst_sleep = sleep;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int st, n, exp_cnt;
        bit exp_err;
        logic [3:0] m_en;
        logic m0;
        void'($urandom(32'd20240611));
        boot_strap = 1; rom_sel = 0;
        do_reset(1'b0);
        // Reset state, hardware reset
        chk(pwr_state == 0, "R1 reset state", pwr_state, 0);
        chk(sd_cke == 0, "R3 reset cke", sd_cke, 0);
        chk(seq_err == 0, "R2 reset err", seq_err, 0);
        chk(bank_en == 0, "R7 reset bank_en", bank_en, 0);
        chk(rfsh_cnt == 0, "R8 reset count", rfsh_cnt, 0);
        chk(ras_n == 4'hF && cas_n == 4'hF, "R6 hw reset strobes", {ras_n, cas_n}, 8'hFF);
        chk(cs0_timing == exp_tim(0), "R10 timing rom_sel=0", cs0_timing, exp_tim(0));
        chk(por_busy == 1, "R4 busy after hw reset", por_busy, 1);
        chk(mclk1 == 0 && mclk2 == 0, "R5 aux clocks stopped", {mclk1, mclk2}, 0);
        // Early step refused during power-on wait (R4, R2)
        m0 = mclk0;
        wr_step = 1; wr_target = 1;
        @(negedge clk); n = 1;
        wr_step = 0;
        chk(pwr_state == 0, "R4 step refused while busy", pwr_state, 0);
        chk(seq_err == 1, "R2 err on refused step", seq_err, 1);
        chk(mclk0 != m0, "R5 mclk0 toggles with strap", mclk0, !m0);
        chk(mclk1 == 0, "R5 mclk1 still stopped", mclk1, 0);
        while (por_busy && n < 1000) begin
            @(negedge clk); n++;
        end
        chk(n == PWR, "R4 power-on wait length", n, PWR);

        // Sleep reset: no wait, strobes held, random stepping to idle
        do_reset(1'b1);
        chk(por_busy == 0, "R4 no wait after sleep reset", por_busy, 0);
        chk(ras_n == 0 && cas_n == 0, "R6 sleep hold strobes", {ras_n, cas_n}, 0);
        chk(seq_err == 0, "R2 err cleared by reset", seq_err, 0);
        st = 0; exp_err = 0;
        for (int i = 0; i < 80 && st < 4; i++) begin
            wr_step = ($urandom_range(0, 9) < 7);
            wr_target = ($urandom_range(0, 1) != 0) ? 3'(st + 1) : 3'($urandom_range(0, 7));
            @(negedge clk);
            if (wr_step) begin
                if (wr_target == 3'(st + 1)) st = st + 1;
                else exp_err = 1;
            end
            wr_step = 0;
            chk(pwr_state == 3'(st), "R1 random step state", pwr_state, st);
            chk(sd_cke == exp_cke(st), "R3 cke by state", sd_cke, exp_cke(st));
            chk(seq_err == exp_err, "R2 random err", seq_err, exp_err);
            chk(ras_n == 0, "R6 hold persists", ras_n, 0);
        end
        while (st < 4) begin
            wr_step = 1; wr_target = 3'(st + 1);
            @(negedge clk); st++;
            wr_step = 0;
            chk(pwr_state == 3'(st), "R1 directed step", pwr_state, st);
        end
        // Write at idle is refused
        wr_step = 1; wr_target = 5;
        @(negedge clk); wr_step = 0;
        chk(pwr_state == 4 && seq_err == 1, "R2 step past idle", {pwr_state, seq_err}, 9);
        // Release strobes
        wr_release = 1;
        @(negedge clk); wr_release = 0;
        chk(ras_n == 4'hF && cas_n == 4'hF, "R6 release strobes", {ras_n, cas_n}, 8'hFF);
        m0 = mclk1;
        @(negedge clk);
        chk(mclk1 != m0 && mclk2 == mclk1, "R5 aux clocks running", {mclk1, mclk2}, {!m0, !m0});

        // Eight directed refreshes to disabled bank
        for (int i = 0; i < 8; i++) begin
            acc_req = 1; acc_burst = 0; acc_bank = 2'(i);
            @(negedge clk);
            chk(rfsh_pulse == 1, "R8 refresh pulse", rfsh_pulse, 1);
            chk(ras_n == 0 && cas_n == 0, "R8 strobes low in refresh", {ras_n, cas_n}, 0);
        end
        acc_req = 0;
        @(negedge clk);
        chk(rfsh_pulse == 0, "R8 pulse one cycle", rfsh_pulse, 0);
        chk(rfsh_cnt == 8, "R8 eight refreshes", rfsh_cnt, 8);
        acc_req = 1; acc_burst = 1; acc_bank = 1;
        @(negedge clk); acc_req = 0; acc_burst = 0;
        chk(rfsh_pulse == 0 && rfsh_cnt == 8, "R8 burst ignored", {rfsh_pulse, rfsh_cnt}, 8);

        // Random bank enables and accesses
        m_en = 0; exp_cnt = 8;
        for (int i = 0; i < 300; i++) begin
            bit trig, fwd;
            wr_bank = ($urandom_range(0, 5) == 0);
            bank_en_in = 4'($urandom_range(0, 15));
            acc_req = ($urandom_range(0, 2) != 0);
            acc_burst = ($urandom_range(0, 3) == 0);
            acc_bank = 2'($urandom_range(0, 3));
            trig = acc_req && !acc_burst && !m_en[acc_bank];
            fwd = acc_req && m_en[acc_bank];
            @(negedge clk);
            if (trig && exp_cnt < 255) exp_cnt++;
            if (wr_bank) m_en = bank_en_in;
            chk(rfsh_pulse == trig, "R8 random refresh", rfsh_pulse, trig);
            chk(acc_fwd == fwd, "R9 random forward", acc_fwd, fwd);
            chk(rfsh_cnt == 8'(exp_cnt), "R8 random count", rfsh_cnt, exp_cnt);
            chk(bank_en == m_en, "R7 bank enables", bank_en, m_en);
        end
        idle_inputs();

        // Hardware reset with other straps
        boot_strap = 0; rom_sel = 1;
        do_reset(1'b0);
        chk(cs0_timing == exp_tim(1), "R10 timing rom_sel=1", cs0_timing, exp_tim(1));
        chk(ras_n == 4'hF, "R6 hw reset ends hold", ras_n, 4'hF);
        chk(bank_en == 0 && rfsh_cnt == 0, "R7 reset clears", {bank_en, rfsh_cnt}, 0);
        m0 = mclk0;
        @(negedge clk);
        chk(mclk0 == m0 && mclk0 == 0, "R5 mclk0 idle strap low", mclk0, 0);
        chk(cs0_timing == exp_tim(1), "R10 timing holds", cs0_timing, exp_tim(1));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule